// File: doc/BRIEF.md
# Byte-Wide Host Bus Slave with Ready Stretching

This block attaches a byte-wide local peripheral to an ISA host bus as a slave. The host places a 24-bit address on its address lines and pulses an address-latch strobe. The block holds that address and compares it against two windows. One window covers memory space and uses the full 24 bits. The other covers I/O space and uses only the low 16 bits. An I/O decode counts only while the host's address-qualify input is low.

The four host strobes (memory read/write, I/O read/write) are brought into the local clock domain through a synchronizer chain. When a synchronized strobe meets a window hit, the block raises one request toward the peripheral. It carries the latched address, the direction, the space and the write byte. The request holds until the peripheral acknowledges. A programmable cycle limit ends any request whose acknowledge never comes.

A memory access stretches the host cycle: the ready output drops as soon as the memory strobe meets a window hit, and it returns high once the internal access has ended. Read data is driven toward the host only during a read strobe that hits a window.

Top module: `isa8_slave`

## Requirements
- R1: The address is loaded from `host_addr` on each clock edge where `host_addr_latch` is high and held otherwise. Every request carries the held value, including bit 0, so changes on `host_addr` after the latch strobe falls have no effect.
- R2: A memory strobe hits when `cfg_mem_base <= addr < cfg_mem_base + cfg_mem_size` (24-bit, unsigned). A memory strobe that misses raises no request, stores nothing and leaves `host_ready` high.
- R3: An I/O strobe hits only when `host_io_qual_n` is low and the low 16 address bits lie in `[cfg_io_base, cfg_io_base + cfg_io_size)`. A hit raises a request with `loc_is_io` = 1; memory requests carry `loc_is_io` = 0. An I/O strobe with `host_io_qual_n` high raises no request and changes no stored byte.
- R4: `host_ready` falls combinationally, in the same cycle, when a memory read or write strobe meets a memory-window hit. It stays low until the internal access ends, then returns high. I/O accesses and misses never drive it low.
- R5: `host_data_oe` is 1 only while a read strobe hits its window (memory read with memory hit, or I/O read with I/O hit and the qualifier low). While it is 1, `host_data_out` carries the byte returned by the last completed access.
- R6: `loc_wdata` is the value of `host_data_in` at the cycle the request is raised. `loc_we` is 1 for write strobes and 0 for read strobes. `loc_req`, `loc_addr` and `loc_wdata` stay unchanged until `loc_ack` is seen.
- R7: If `loc_ack` never comes, `loc_req` stays high for exactly `cfg_timeout` cycles (`cfg_timeout` >= 1) and then falls. `timeout_flag` then becomes 1 and stays 1 until reset, `host_ready` is released, and the returned byte is 0xFF.
- R8: Each host strobe yields at most one request. No new request is raised until all four strobes have been released.
- R9: While `rst_n` is low, the outputs are `host_ready` = 1, `host_data_oe` = 0, `loc_req` = 0 and `timeout_flag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 24 | Host address lines |
| host_addr_latch | input | 1 | Address-latch strobe, high while the address is valid |
| host_io_qual_n | input | 1 | Low when an I/O address is valid |
| host_memrd_n | input | 1 | Memory read strobe, active low |
| host_memwr_n | input | 1 | Memory write strobe, active low |
| host_iord_n | input | 1 | I/O read strobe, active low |
| host_iowr_n | input | 1 | I/O write strobe, active low |
| host_data_in | input | 8 | Data from the host bus |
| host_data_out | output | 8 | Data toward the host bus |
| host_data_oe | output | 1 | Output enable of the data pads |
| host_ready | output | 1 | High when the host cycle may complete |
| cfg_mem_base | input | 24 | Memory window start |
| cfg_mem_size | input | 24 | Memory window length in bytes |
| cfg_io_base | input | 16 | I/O window start |
| cfg_io_size | input | 16 | I/O window length |
| cfg_timeout | input | 8 | Request cycle limit |
| loc_req | output | 1 | Request to the peripheral |
| loc_we | output | 1 | Request is a write |
| loc_is_io | output | 1 | Request targets I/O space |
| loc_addr | output | 24 | Request address |
| loc_wdata | output | 8 | Request write byte |
| loc_ack | input | 1 | Peripheral acknowledge |
| loc_rdata | input | 8 | Peripheral read byte, valid with acknowledge |
| timeout_flag | output | 1 | Sticky timeout indication |

## Verification
A state machine stuck in its busy state shows at the ports as `host_ready` held low on the next memory cycle, for the whole timeout window. A state machine that leaves its done state too early shows as a second request rising during the same strobe, a few clocks after the first acknowledge. A wrong window comparison shows within the synchronizer delay as a request that is missing or unwanted. On memory cycles it shows at once, in the same cycle, as a wrong `host_ready` level. A stale latched address or data byte is visible on `loc_addr` or `loc_wdata` when the request rises.

// File: rtl/isa8_slave_pkg.sv
package isa8_slave_pkg;

   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_BUSY = 2'd1,
      XS_DONE = 2'd2
   } xfer_state_e;

   // host strobe bundle, all active low as seen on the bus
   typedef struct packed {
      logic qual_n;
      logic iowr_n;
      logic iord_n;
      logic memwr_n;
      logic memrd_n;
   } strobe_t;

   localparam int STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/isa8_slave_sync.sv
module isa8_slave_sync #(
   parameter int          W       = 5,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES <= 1) begin : g_single
         logic [W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [W-1:0] chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
            end else begin
               chain[0] <= d;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/isa8_slave_window.sv
module isa8_slave_window #(
   parameter int AW = 24
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] size,
   output logic          hit
);

   logic [AW-1:0] offset;

   // unsigned wrap folds both bounds into one compare
   assign offset = addr - base;
   assign hit    = (offset < size);

endmodule

// File: rtl/isa8_slave_ctrl.sv
module isa8_slave_ctrl
   import isa8_slave_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 8,
   parameter int TO_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  strobe_t           strb,
   input  logic              mem_hit,
   input  logic              io_hit,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] data_in,
   input  logic [TO_W-1:0]   cfg_timeout,
   input  logic              loc_ack,
   input  logic [DATA_W-1:0] loc_rdata,
   output logic              loc_req,
   output logic              loc_we,
   output logic              loc_is_io,
   output logic [ADDR_W-1:0] loc_addr,
   output logic [DATA_W-1:0] loc_wdata,
   output logic [DATA_W-1:0] rdata_q,
   output logic              timeout_flag,
   output logic              in_done
);

   xfer_state_e state;
   logic [TO_W-1:0] wait_cnt;
   logic mem_go, io_go, all_idle;

   assign mem_go   = (!strb.memrd_n || !strb.memwr_n) && mem_hit;
   assign io_go    = (!strb.iord_n || !strb.iowr_n) && io_hit && !strb.qual_n;
   assign all_idle = strb.memrd_n && strb.memwr_n && strb.iord_n && strb.iowr_n;
   assign in_done  = (state == XS_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= XS_IDLE;
         loc_req      <= 1'b0;
         loc_we       <= 1'b0;
         loc_is_io    <= 1'b0;
         loc_addr     <= '0;
         loc_wdata    <= '0;
         rdata_q      <= '0;
         wait_cnt     <= '0;
         timeout_flag <= 1'b0;
      end else begin
         unique case (state)
            XS_IDLE: begin
               if (mem_go || io_go) begin
                  state     <= XS_BUSY;
                  loc_req   <= 1'b1;
                  loc_we    <= mem_go ? !strb.memwr_n : !strb.iowr_n;
                  loc_is_io <= !mem_go;
                  loc_addr  <= addr_q;
                  loc_wdata <= data_in;
                  wait_cnt  <= '0;
               end
            end
            XS_BUSY: begin
               if (loc_ack) begin
                  loc_req <= 1'b0;
                  rdata_q <= loc_rdata;
                  state   <= XS_DONE;
               end else if (wait_cnt == (cfg_timeout - TO_W'(1))) begin
                  loc_req      <= 1'b0;
                  rdata_q      <= '1;
                  timeout_flag <= 1'b1;
                  state        <= XS_DONE;
               end else begin
                  wait_cnt <= wait_cnt + TO_W'(1);
               end
            end
            XS_DONE: begin
               if (all_idle) state <= XS_IDLE;
            end
            default: state <= XS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/isa8_slave.sv
module isa8_slave
   import isa8_slave_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int IO_AW       = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TO_W        = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_addr_latch,
   input  logic              host_io_qual_n,
   input  logic              host_memrd_n,
   input  logic              host_memwr_n,
   input  logic              host_iord_n,
   input  logic              host_iowr_n,
   input  logic [DATA_W-1:0] host_data_in,
   output logic [DATA_W-1:0] host_data_out,
   output logic              host_data_oe,
   output logic              host_ready,
   input  logic [ADDR_W-1:0] cfg_mem_base,
   input  logic [ADDR_W-1:0] cfg_mem_size,
   input  logic [IO_AW-1:0]  cfg_io_base,
   input  logic [IO_AW-1:0]  cfg_io_size,
   input  logic [TO_W-1:0]   cfg_timeout,
   output logic              loc_req,
   output logic              loc_we,
   output logic              loc_is_io,
   output logic [ADDR_W-1:0] loc_addr,
   output logic [DATA_W-1:0] loc_wdata,
   input  logic              loc_ack,
   input  logic [DATA_W-1:0] loc_rdata,
   output logic              timeout_flag
);

   initial begin : param_chk
      assert (IO_AW <= ADDR_W) else $error("IO_AW must not exceed ADDR_W");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
      assert (TO_W >= 1) else $error("TO_W must be at least 1");
   end

   logic [ADDR_W-1:0] addr_q;
   logic              mem_hit, io_hit, in_done;
   logic [DATA_W-1:0] rdata_q;
   strobe_t           raw_strb, sync_strb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               addr_q <= '0;
      else if (host_addr_latch) addr_q <= host_addr;
   end

   assign raw_strb = '{qual_n:  host_io_qual_n,
                       iowr_n:  host_iowr_n,
                       iord_n:  host_iord_n,
                       memwr_n: host_memwr_n,
                       memrd_n: host_memrd_n};

   isa8_slave_sync #(.W(STROBE_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d (raw_strb),
      .q (sync_strb)
   );

   isa8_slave_window #(.AW(ADDR_W)) u_mem_win (
      .addr (addr_q),
      .base (cfg_mem_base),
      .size (cfg_mem_size),
      .hit  (mem_hit)
   );

   isa8_slave_window #(.AW(IO_AW)) u_io_win (
      .addr (addr_q[IO_AW-1:0]),
      .base (cfg_io_base),
      .size (cfg_io_size),
      .hit  (io_hit)
   );

   isa8_slave_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TO_W(TO_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .strb         (sync_strb),
      .mem_hit      (mem_hit),
      .io_hit       (io_hit),
      .addr_q       (addr_q),
      .data_in      (host_data_in),
      .cfg_timeout  (cfg_timeout),
      .loc_ack      (loc_ack),
      .loc_rdata    (loc_rdata),
      .loc_req      (loc_req),
      .loc_we       (loc_we),
      .loc_is_io    (loc_is_io),
      .loc_addr     (loc_addr),
      .loc_wdata    (loc_wdata),
      .rdata_q      (rdata_q),
      .timeout_flag (timeout_flag),
      .in_done      (in_done)
   );

   // stretch straight from the raw strobe so the host sees it in time
   assign host_ready    = !((!host_memrd_n || !host_memwr_n) && mem_hit && !in_done);
   assign host_data_oe  = (!host_memrd_n && mem_hit) ||
                          (!host_iord_n && !host_io_qual_n && io_hit);
   assign host_data_out = rdata_q;

endmodule

// File: rtl/isa8_slave_chk.sv
module isa8_slave_chk #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_memrd_n,
   input logic              host_memwr_n,
   input logic              host_iord_n,
   input logic              host_ready,
   input logic              host_data_oe,
   input logic              loc_req,
   input logic              loc_ack,
   input logic [ADDR_W-1:0] loc_addr,
   input logic [DATA_W-1:0] loc_wdata,
   input logic              timeout_flag
);

   // R4
   ready_mem_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_ready |-> (!host_memrd_n || !host_memwr_n));

   // R5
   oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_data_oe |-> (!host_memrd_n || !host_iord_n));

   // R6
   req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_req && !loc_ack && !timeout_flag) |=> (loc_req || timeout_flag));

   // R6
   req_payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_req && $past(loc_req)) |-> ($stable(loc_addr) && $stable(loc_wdata)));

   // R7
   timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_flag |=> timeout_flag);

   // R8
   no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(loc_req) |=> !loc_req);

endmodule

bind isa8_slave isa8_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_memrd_n (host_memrd_n),
   .host_memwr_n (host_memwr_n),
   .host_iord_n  (host_iord_n),
   .host_ready   (host_ready),
   .host_data_oe (host_data_oe),
   .loc_req      (loc_req),
   .loc_ack      (loc_ack),
   .loc_addr     (loc_addr),
   .loc_wdata    (loc_wdata),
   .timeout_flag (timeout_flag)
);

// File: tb/isa8_slave_test.sv
`timescale 1ns/1ps
module isa8_slave_test;

   localparam int TMO = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] host_addr = '0;
   logic        host_addr_latch = 1'b0;
   logic        host_io_qual_n = 1'b1;
   logic        host_memrd_n = 1'b1, host_memwr_n = 1'b1;
   logic        host_iord_n = 1'b1, host_iowr_n = 1'b1;
   logic [7:0]  host_data_in = '0;
   logic [7:0]  host_data_out;
   logic        host_data_oe, host_ready;
   logic        loc_req, loc_we, loc_is_io;
   logic [23:0] loc_addr;
   logic [7:0]  loc_wdata;
   logic        loc_ack = 1'b0;
   logic [7:0]  loc_rdata = '0;
   logic        timeout_flag;

   int checks = 0, failures = 0;

   always #2.5 clk = ~clk;

   isa8_slave uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_addr_latch(host_addr_latch),
      .host_io_qual_n(host_io_qual_n), .host_memrd_n(host_memrd_n), .host_memwr_n(host_memwr_n),
      .host_iord_n(host_iord_n), .host_iowr_n(host_iowr_n), .host_data_in(host_data_in),
      .host_data_out(host_data_out), .host_data_oe(host_data_oe), .host_ready(host_ready),
      .cfg_mem_base(24'h0C8000), .cfg_mem_size(24'h004000),
      .cfg_io_base(16'h0300), .cfg_io_size(16'h0010), .cfg_timeout(8'(TMO)),
      .loc_req(loc_req), .loc_we(loc_we), .loc_is_io(loc_is_io), .loc_addr(loc_addr),
      .loc_wdata(loc_wdata), .loc_ack(loc_ack), .loc_rdata(loc_rdata), .timeout_flag(timeout_flag)
   );

   // peripheral model: 16 bytes per space, acknowledge after a set delay
   logic [7:0]  pmem [32];
   logic [7:0]  exp_mem [32];
   int          ack_dly = 0, dly_cnt = 0;
   logic        resp_en = 1'b1;
   logic [23:0] seen_addr = '0;
   logic [7:0]  seen_wdata = '0;
   logic        seen_we = 1'b0, seen_io = 1'b0;

   initial begin
      for (int i = 0; i < 32; i++) begin
         pmem[i]    = 8'h90 ^ 8'(i);
         exp_mem[i] = 8'h90 ^ 8'(i);
      end
   end

   always @(posedge clk) begin
      loc_ack <= 1'b0;
      if (loc_req && !loc_ack && resp_en) begin
         if (dly_cnt >= ack_dly) begin
            loc_ack    <= 1'b1;
            dly_cnt    <= 0;
            loc_rdata  <= pmem[{loc_is_io, loc_addr[3:0]}];
            if (loc_we) pmem[{loc_is_io, loc_addr[3:0]}] <= loc_wdata;
            seen_addr  <= loc_addr;
            seen_wdata <= loc_wdata;
            seen_we    <= loc_we;
            seen_io    <= loc_is_io;
         end else begin
            dly_cnt <= dly_cnt + 1;
         end
      end
   end

   int   req_rises = 0, req_high = 0;
   logic req_prev = 1'b0;
   always @(negedge clk) begin
      if (loc_req && !req_prev) req_rises++;
      if (loc_req) req_high++;
      req_prev = loc_req;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // kind: 0 mem write, 1 mem read, 2 io write, 3 io read
   typedef struct packed {
      logic [1:0]  kind;
      logic        qual_n;
      logic [23:0] addr;
      logic [7:0]  data;
      logic        hit;
      logic [3:0]  dly;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 1'b1, 24'h0C8003, 8'hA5, 1'b1, 4'd0},
      '{2'd0, 1'b1, 24'h0C8002, 8'h11, 1'b1, 4'd3},
      '{2'd1, 1'b1, 24'h0C8003, 8'h00, 1'b1, 4'd5},
      '{2'd1, 1'b1, 24'h0C8002, 8'h00, 1'b1, 4'd0},
      '{2'd0, 1'b1, 24'h0CBFFF, 8'h3C, 1'b1, 4'd2},
      '{2'd1, 1'b1, 24'h0CBFFF, 8'h00, 1'b1, 4'd1},
      '{2'd0, 1'b1, 24'h0CC000, 8'h77, 1'b0, 4'd0},
      '{2'd1, 1'b1, 24'h0C7FFF, 8'h00, 1'b0, 4'd0},
      '{2'd2, 1'b0, 24'h00030E, 8'h5A, 1'b1, 4'd1},
      '{2'd3, 1'b0, 24'h00030E, 8'h00, 1'b1, 4'd0},
      '{2'd2, 1'b0, 24'h000310, 8'h66, 1'b0, 4'd0},
      '{2'd2, 1'b1, 24'h000305, 8'h99, 1'b0, 4'd0},
      '{2'd3, 1'b0, 24'h000305, 8'h00, 1'b1, 4'd2},
      '{2'd1, 1'b1, 24'h0C8000, 8'h00, 1'b1, 4'd0}
   };

   task automatic set_strobe(input logic [1:0] kind, input logic lvl);
      case (kind)
         2'd0: host_memwr_n = lvl;
         2'd1: host_memrd_n = lvl;
         2'd2: host_iowr_n  = lvl;
         default: host_iord_n = lvl;
      endcase
   endtask

   task automatic run_vec(input vec_t v);
      logic       is_io = v.kind[1];
      logic       is_rd = v.kind[0];
      logic [4:0] idx   = {is_io, v.addr[3:0]};
      string      sp    = is_io ? "R3" : "R2";
      @(negedge clk);
      host_addr = v.addr; host_addr_latch = 1'b1; host_io_qual_n = v.qual_n;
      host_data_in = v.data; ack_dly = int'(v.dly);
      @(negedge clk);
      host_addr_latch = 1'b0; host_addr = 24'hFFFFFF;
      req_rises = 0;
      @(negedge clk);
      set_strobe(v.kind, 1'b0);
      #1;
      if (!is_io) check(host_ready == !v.hit, "R4", "ready at strobe", 32'(host_ready), 32'(!v.hit));
      if (!is_io && v.hit) begin
         for (int k = 0; k < 60 && !host_ready; k++) @(negedge clk);
      end else begin
         repeat (20) @(negedge clk);
      end
      check(host_ready == 1'b1, "R4", "ready after access", 32'(host_ready), 32'd1);
      if (is_rd) begin
         check(host_data_oe == v.hit, "R5", "oe during read", 32'(host_data_oe), 32'(v.hit));
         if (v.hit) check(host_data_out == exp_mem[idx], "R5", "read byte",
                          32'(host_data_out), 32'(exp_mem[idx]));
      end
      set_strobe(v.kind, 1'b1);
      repeat (6) @(negedge clk);
      check(host_data_oe == 1'b0, "R5", "oe after release", 32'(host_data_oe), 32'd0);
      check(req_rises == (v.hit ? 1 : 0), v.hit ? "R8" : sp, "request count",
            32'(req_rises), 32'(v.hit));
      if (v.hit) begin
         check(seen_addr == v.addr, "R1", "latched address", 32'(seen_addr), 32'(v.addr));
         check(seen_we == !is_rd, "R6", "direction", 32'(seen_we), 32'(!is_rd));
         check(seen_io == is_io, "R3", "space bit", 32'(seen_io), 32'(is_io));
         if (!is_rd) begin
            check(seen_wdata == v.data, "R6", "write byte", 32'(seen_wdata), 32'(v.data));
            exp_mem[idx] = v.data;
         end
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check(host_ready == 1'b1, "R9", "ready in reset", 32'(host_ready), 32'd1);
      check(host_data_oe == 1'b0, "R9", "oe in reset", 32'(host_data_oe), 32'd0);
      check(loc_req == 1'b0, "R9", "req in reset", 32'(loc_req), 32'd0);
      check(timeout_flag == 1'b0, "R9", "flag in reset", 32'(timeout_flag), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      check(timeout_flag == 1'b0, "R7", "no timeout on acknowledged accesses",
            32'(timeout_flag), 32'd0);

      // R7 missing acknowledge on a memory read
      resp_en = 1'b0;
      @(negedge clk);
      host_addr = 24'h0C8001; host_addr_latch = 1'b1; host_io_qual_n = 1'b1;
      @(negedge clk);
      host_addr_latch = 1'b0; req_high = 0;
      @(negedge clk);
      host_memrd_n = 1'b0;
      #1;
      check(host_ready == 1'b0, "R4", "stretch on timeout read", 32'(host_ready), 32'd0);
      for (int k = 0; k < 60 && !host_ready; k++) @(negedge clk);
      check(req_high == TMO, "R7", "request high cycles", 32'(req_high), 32'(TMO));
      check(timeout_flag == 1'b1, "R7", "flag set", 32'(timeout_flag), 32'd1);
      check(host_ready == 1'b1, "R7", "ready released", 32'(host_ready), 32'd1);
      check(host_data_out == 8'hFF, "R7", "timeout read byte", 32'(host_data_out), 32'hFF);
      host_memrd_n = 1'b1;
      resp_en = 1'b1;
      repeat (6) @(negedge clk);

      // normal access afterwards; flag stays set
      run_vec(VECS[4]);
      run_vec(VECS[5]);
      check(timeout_flag == 1'b1, "R7", "flag sticky", 32'(timeout_flag), 32'd1);

      finish_run();
   end

endmodule